// File: doc/BRIEF.md
# PTP Frame Event Tagger

This block watches a byte-wide Ethernet frame stream, on either the receive or the transmit side, and picks out Layer 2 precision-time-protocol frames. It records the value of a free-running time-sync counter on the first byte of every frame. From each frame it collects the EtherType, the message type nibble and the 16-bit sequence identifier. When a frame turns out to be PTP and its sequence identifier has fully arrived, the block sends one event toward a downstream event FIFO. The event carries a packed 32-bit event word and the captured 32-bit timestamp.

The event word packs the sequence identifier, the message type and a direction code into fixed fields. Software can therefore pair each timestamp with its frame by comparing that single word. Whether the block tags receive or transmit traffic is set by a parameter when it is instantiated. Frames with a VLAN tag and PTP carried over UDP/IPv4 are not recognised.

Top module: `ptp_evt_tagger`

## Requirements
- R1: After reset, `evt_vld` is low and both `evt_word` and `evt_stamp` are zero.
- R2: A frame is PTP only when byte 12 is 0x88 and byte 13 is 0xF7, with byte 0 being the byte that carries `byte_sof`. Frames with any other EtherType produce no event, and this includes the byte-swapped value 0xF788.
- R3: Bits 15:0 of `evt_word` hold the sequence identifier, taken big-endian from bytes 30 (high) and 31 (low).
- R4: Bits 19:16 of `evt_word` hold the low nibble of byte 14. Bits 31:24 are zero.
- R5: Bits 23:20 of `evt_word` are 4 when `IS_TX` is 0 (receive) and 5 when `IS_TX` is 1 (transmit).
- R6: `evt_stamp` equals the value of `ts_count` on the clock edge that accepts the frame's first byte.
- R7: `evt_vld` is high for exactly one cycle, in the cycle after the edge that accepts byte 31. Bytes after byte 31 in the same frame cause no further event.
- R8: A frame whose `byte_eof` comes before byte 31 gives no event. A frame whose `byte_eof` is on byte 31 still gives its event.
- R9: Cycles with `byte_vld` low do not advance the byte position. Valid bytes that arrive after `byte_eof` and before the next `byte_sof` are ignored.
- R10: A `byte_sof` in the middle of a frame drops that frame and starts a new one at byte 0, with a new timestamp.
- R11: Outside the event cycle, `evt_word` and `evt_stamp` keep the values of the last event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld | input | 1 | Stream byte is valid this cycle |
| byte_sof | input | 1 | Valid byte is the first byte of a frame |
| byte_eof | input | 1 | Valid byte is the last byte of a frame |
| byte_data | input | 8 | Stream byte |
| ts_count | input | TS_W (32) | Time-sync counter value |
| evt_vld | output | 1 | One-cycle event strobe |
| evt_word | output | 32 | Packed event word: sequence id, message type, direction code |
| evt_stamp | output | TS_W (32) | Counter value captured at the start of the frame |

## Verification
A receive instance and a transmit instance see the same stream. This separates the direction code from all other fields.

Directed frames check the following cases:
- The correct EtherType against one-bit-off and byte-swapped values, which shows that the match uses both bytes in the right order.
- Lengths of 31 and 32 bytes, which pin down the exact byte on which the event fires.
- Frames restarted part-way through, which show that the position and the timestamp restart together.
- Idle gaps inside frames and stray valid bytes between frames, which separate counting valid bytes from counting cycles.

Seeded random frames then mix lengths, EtherTypes, gap densities and unterminated frames. Every idle cycle also checks that the last event word and timestamp are held.

// File: rtl/ptp_tag_pkg.sv
package ptp_tag_pkg;

    // EtherType that marks a Layer 2 PTP frame
    localparam logic [15:0] PTP_ETYPE = 16'h88F7;

    // direction codes placed in the event-kind field
    localparam logic [3:0] KIND_RX = 4'h4;
    localparam logic [3:0] KIND_TX = 4'h5;

    typedef struct packed {
        logic [7:0]  rsvd;
        logic [3:0]  kind;
        logic [3:0]  msg;
        logic [15:0] seq;
    } evt_word_t;

    function automatic evt_word_t pack_event(logic [3:0] kind,
                                             logic [3:0] msg,
                                             logic [15:0] seq);
        evt_word_t w;
        w.rsvd = 8'h00;
        w.kind = kind;
        w.msg  = msg;
        w.seq  = seq;
        return w;
    endfunction

endpackage

// File: rtl/ptp_frame_pos.sv
// Tracks whether a frame is open and the position of the current byte in it.
module ptp_frame_pos #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             byte_vld,
    input  logic             byte_sof,
    input  logic             byte_eof,
    output logic             beat_vld,
    output logic [IDX_W-1:0] beat_idx
);
    localparam logic [IDX_W-1:0] IDX_MAX = '1;

    logic             active_q;
    logic [IDX_W-1:0] next_q;

    always_comb begin
        beat_vld = byte_vld && (byte_sof || active_q);
        beat_idx = byte_sof ? '0 : next_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            next_q   <= '0;
        end else if (beat_vld) begin
            active_q <= !byte_eof;
            // saturate so that a long frame never reaches the trigger index again
            next_q   <= (beat_idx == IDX_MAX) ? IDX_MAX : beat_idx + 1'b1;
        end
    end
endmodule

// File: rtl/ptp_field_grab.sv
// Captures the header fields and the start-of-frame timestamp.
module ptp_field_grab #(
    parameter int TS_W      = 32,
    parameter int IDX_W     = 6,
    parameter int ETYPE_OFS = 12,
    parameter int MSG_OFS   = 14,
    parameter int SEQ_OFS   = 30
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             beat_vld,
    input  logic [IDX_W-1:0] beat_idx,
    input  logic [7:0]       byte_data,
    input  logic [TS_W-1:0]  ts_count,
    output logic [15:0]      etype_q,
    output logic [3:0]       msg_q,
    output logic [7:0]       seq_hi_q,
    output logic [TS_W-1:0]  stamp_q
);
    localparam logic [IDX_W-1:0] AT_MSG = IDX_W'(MSG_OFS);
    localparam logic [IDX_W-1:0] AT_SEQ = IDX_W'(SEQ_OFS);

    // one capture register per EtherType byte, most significant first
    for (genvar g = 0; g < 2; g++) begin : g_etype
        localparam logic [IDX_W-1:0] AT = IDX_W'(ETYPE_OFS + g);
        logic [7:0] byte_q;
        always_ff @(posedge clk) begin
            if (rst)
                byte_q <= '0;
            else if (beat_vld && beat_idx == AT)
                byte_q <= byte_data;
        end
    end

    assign etype_q = {g_etype[0].byte_q, g_etype[1].byte_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_q    <= '0;
            seq_hi_q <= '0;
            stamp_q  <= '0;
        end else if (beat_vld) begin
            if (beat_idx == '0)
                stamp_q <= ts_count;
            if (beat_idx == AT_MSG)
                msg_q <= byte_data[3:0];
            if (beat_idx == AT_SEQ)
                seq_hi_q <= byte_data;
        end
    end
endmodule

// File: rtl/ptp_evt_emit.sv
// Decides on the trigger byte and registers the event outputs.
module ptp_evt_emit
    import ptp_tag_pkg::*;
#(
    parameter int TS_W    = 32,
    parameter int IDX_W   = 6,
    parameter int SEQ_OFS = 30,
    parameter bit IS_TX   = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             beat_vld,
    input  logic [IDX_W-1:0] beat_idx,
    input  logic [7:0]       byte_data,
    input  logic [15:0]      etype,
    input  logic [3:0]       msg,
    input  logic [7:0]       seq_hi,
    input  logic [TS_W-1:0]  stamp,
    output logic             evt_vld,
    output logic [31:0]      evt_word,
    output logic [TS_W-1:0]  evt_stamp
);
    localparam logic [IDX_W-1:0] AT_LAST = IDX_W'(SEQ_OFS + 1);

    logic [3:0] kind_c;
    logic       fire;

    if (IS_TX) begin : g_kind_tx
        assign kind_c = KIND_TX;
    end else begin : g_kind_rx
        assign kind_c = KIND_RX;
    end

    assign fire = beat_vld && (beat_idx == AT_LAST) && (etype == PTP_ETYPE);

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_vld   <= 1'b0;
            evt_word  <= '0;
            evt_stamp <= '0;
        end else begin
            evt_vld <= fire;
            if (fire) begin
                evt_word  <= pack_event(kind_c, msg, {seq_hi, byte_data});
                evt_stamp <= stamp;
            end
        end
    end
endmodule

// File: rtl/ptp_evt_tagger.sv
module ptp_evt_tagger
    import ptp_tag_pkg::*;
#(
    parameter int TS_W      = 32,
    parameter bit IS_TX     = 1'b0,
    parameter int ETYPE_OFS = 12,
    parameter int MSG_OFS   = 14,
    parameter int SEQ_OFS   = 30
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            byte_vld,
    input  logic            byte_sof,
    input  logic            byte_eof,
    input  logic [7:0]      byte_data,
    input  logic [TS_W-1:0] ts_count,
    output logic            evt_vld,
    output logic [31:0]     evt_word,
    output logic [TS_W-1:0] evt_stamp
);
    localparam int LAST_OFS = SEQ_OFS + 1;
    // one spare bit so the saturated position never equals the trigger index
    localparam int IDX_W    = $clog2(LAST_OFS + 1) + 1;

    logic             beat_vld;
    logic [IDX_W-1:0] beat_idx;
    logic [15:0]      etype_q;
    logic [3:0]       msg_q;
    logic [7:0]       seq_hi_q;
    logic [TS_W-1:0]  stamp_q;

    ptp_frame_pos #(.IDX_W(IDX_W)) pos_i (
        .clk      (clk),
        .rst      (rst),
        .byte_vld (byte_vld),
        .byte_sof (byte_sof),
        .byte_eof (byte_eof),
        .beat_vld (beat_vld),
        .beat_idx (beat_idx)
    );

    ptp_field_grab #(
        .TS_W      (TS_W),
        .IDX_W     (IDX_W),
        .ETYPE_OFS (ETYPE_OFS),
        .MSG_OFS   (MSG_OFS),
        .SEQ_OFS   (SEQ_OFS)
    ) grab_i (
        .clk       (clk),
        .rst       (rst),
        .beat_vld  (beat_vld),
        .beat_idx  (beat_idx),
        .byte_data (byte_data),
        .ts_count  (ts_count),
        .etype_q   (etype_q),
        .msg_q     (msg_q),
        .seq_hi_q  (seq_hi_q),
        .stamp_q   (stamp_q)
    );

    ptp_evt_emit #(
        .TS_W    (TS_W),
        .IDX_W   (IDX_W),
        .SEQ_OFS (SEQ_OFS),
        .IS_TX   (IS_TX)
    ) emit_i (
        .clk       (clk),
        .rst       (rst),
        .beat_vld  (beat_vld),
        .beat_idx  (beat_idx),
        .byte_data (byte_data),
        .etype     (etype_q),
        .msg       (msg_q),
        .seq_hi    (seq_hi_q),
        .stamp     (stamp_q),
        .evt_vld   (evt_vld),
        .evt_word  (evt_word),
        .evt_stamp (evt_stamp)
    );
endmodule

// File: rtl/ptp_evt_tagger_chk.sv
module ptp_evt_tagger_chk #(
    parameter int TS_W  = 32,
    parameter bit IS_TX = 1'b0
) (
    input logic            clk,
    input logic            rst,
    input logic            byte_vld,
    input logic            evt_vld,
    input logic [31:0]     evt_word,
    input logic [TS_W-1:0] evt_stamp
);
    localparam logic [3:0] KIND_EXP = IS_TX ? 4'h5 : 4'h4;

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!evt_vld && evt_word == 32'h0 && evt_stamp == '0));

    // R7
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        evt_vld |=> !evt_vld);

    // R7
    after_byte_chk: assert property (@(posedge clk) disable iff (rst)
        evt_vld |-> $past(byte_vld));

    // R5
    kind_code_chk: assert property (@(posedge clk) disable iff (rst)
        evt_vld |-> evt_word[23:20] == KIND_EXP);

    // R4
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        evt_vld |-> evt_word[31:24] == 8'h00);

    // R11
    hold_out_chk: assert property (@(posedge clk) disable iff (rst)
        !evt_vld |-> ($stable(evt_word) && $stable(evt_stamp)));
endmodule

bind ptp_evt_tagger ptp_evt_tagger_chk #(.TS_W(TS_W), .IS_TX(IS_TX)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .byte_vld  (byte_vld),
    .evt_vld   (evt_vld),
    .evt_word  (evt_word),
    .evt_stamp (evt_stamp)
);

// File: tb/ptp_evt_tagger_tb.sv
`timescale 1ns/1ps
module ptp_evt_tagger_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        byte_vld = 1'b0;
    logic        byte_sof = 1'b0;
    logic        byte_eof = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic [31:0] ts_count = 32'h0000_1000;

    logic        rx_vld, tx_vld;
    logic [31:0] rx_word, tx_word, rx_stamp, tx_stamp;

    always #2.5 clk = ~clk;

    ptp_evt_tagger #(.IS_TX(1'b0)) dut_i (
        .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_sof(byte_sof),
        .byte_eof(byte_eof), .byte_data(byte_data), .ts_count(ts_count),
        .evt_vld(rx_vld), .evt_word(rx_word), .evt_stamp(rx_stamp)
    );

    ptp_evt_tagger #(.IS_TX(1'b1)) dut_tx_i (
        .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_sof(byte_sof),
        .byte_eof(byte_eof), .byte_data(byte_data), .ts_count(ts_count),
        .evt_vld(tx_vld), .evt_word(tx_word), .evt_stamp(tx_stamp)
    );

    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;
    bit          exp_fire = 1'b0;
    logic [31:0] exp_w, exp_tw, exp_s, pend_stamp;
    logic [31:0] last_w = 32'h0, last_tw = 32'h0, last_s = 32'h0;
    string       cur_req = "R2";

    function automatic logic [31:0] mk_word(logic [3:0] kind, logic [3:0] msg, logic [15:0] seq);
        return {8'h00, kind, msg, seq};
    endfunction

    task automatic chk32(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_out();
        if (exp_fire) begin
            chk32(cur_req, "rx event strobe", {31'b0, rx_vld}, 32'h1);
            chk32("R3 R4", "rx event word", rx_word, exp_w);
            chk32("R5", "tx event word", tx_word, exp_tw);
            chk32("R6", "rx stamp", rx_stamp, exp_s);
            chk32("R6", "tx stamp", tx_stamp, exp_s);
            last_w   = exp_w;
            last_tw  = exp_tw;
            last_s   = exp_s;
            exp_fire = 1'b0;
        end else begin
            chk32(cur_req, "no rx event", {31'b0, rx_vld}, 32'h0);
            chk32(cur_req, "no tx event", {31'b0, tx_vld}, 32'h0);
            chk32("R11", "held word", rx_word, last_w);
            chk32("R11", "held tx word", tx_word, last_tw);
            chk32("R11", "held stamp", rx_stamp, last_s);
        end
    endtask

    task automatic step(bit v, bit s, bit e, logic [7:0] d);
        @(negedge clk);
        check_out();
        ts_count  = ts_count + 32'd13;
        byte_vld  = v;
        byte_sof  = s;
        byte_eof  = e;
        byte_data = d;
        if (v && s) pend_stamp = ts_count;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) step(1'b0, 1'b0, 1'b0, 8'($urandom));
    endtask

    task automatic send_frame(int len, logic [15:0] et, logic [3:0] msg,
                              logic [15:0] seq, bit close, int gap_pct);
        for (int i = 0; i < len; i++) begin
            logic [7:0] b;
            b = 8'($urandom);
            if (i == 12) b = et[15:8];
            if (i == 13) b = et[7:0];
            if (i == 14) b = {b[7:4], msg};
            if (i == 30) b = seq[15:8];
            if (i == 31) b = seq[7:0];
            while (gap_pct > 0 && int'($urandom % 100) < gap_pct)
                step(1'b0, 1'b0, 1'b0, 8'($urandom));
            step(1'b1, i == 0, close && (i == len - 1), b);
            if (i == 31 && et == 16'h88F7) begin
                exp_fire = 1'b1;
                exp_w    = mk_word(4'h4, msg, seq);
                exp_tw   = mk_word(4'h5, msg, seq);
                exp_s    = pend_stamp;
            end
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R7 watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state at the ports
        chk32("R1", "reset strobe", {31'b0, rx_vld}, 32'h0);
        chk32("R1", "reset word", rx_word, 32'h0);
        chk32("R1", "reset stamp", rx_stamp, 32'h0);

        // R2 R3 R4 basic PTP frame
        cur_req = "R2";
        send_frame(40, 16'h88F7, 4'hB, 16'hA55A, 1'b1, 0);
        idle(3);
        send_frame(48, 16'h88F7, 4'h0, 16'hFFFF, 1'b1, 0);
        idle(2);
        // R2 near-miss and byte-swapped EtherTypes
        send_frame(40, 16'h88F6, 4'h1, 16'h1234, 1'b1, 0);
        send_frame(40, 16'hF788, 4'h1, 16'h1234, 1'b1, 0);
        send_frame(40, 16'h0800, 4'h2, 16'h0001, 1'b1, 0);
        idle(3);

        // R8 length boundary around byte 31
        cur_req = "R8";
        send_frame(31, 16'h88F7, 4'h3, 16'h0BAD, 1'b1, 0);
        idle(3);
        send_frame(32, 16'h88F7, 4'h9, 16'h00C3, 1'b1, 0);
        idle(3);
        send_frame(1, 16'h88F7, 4'h9, 16'h00C3, 1'b1, 0);
        idle(2);

        // R9 gaps inside a frame, then stray bytes outside any frame
        cur_req = "R9";
        send_frame(45, 16'h88F7, 4'h6, 16'h5A01, 1'b1, 60);
        for (int k = 0; k < 40; k++) step(1'b1, 1'b0, 1'b0, (k % 2 == 0) ? 8'h88 : 8'hF7);
        idle(3);

        // R10 restart in the middle of a frame
        cur_req = "R10";
        send_frame(25, 16'h88F7, 4'h3, 16'h1111, 1'b0, 0);
        send_frame(36, 16'h88F7, 4'h7, 16'h2222, 1'b1, 0);
        idle(2);
        send_frame(31, 16'h88F7, 4'h3, 16'h3333, 1'b0, 0);
        send_frame(33, 16'h88F7, 4'h8, 16'h4444, 1'b1, 0);
        idle(2);

        // R7 long frame: one event only
        cur_req = "R7";
        send_frame(72, 16'h88F7, 4'hE, 16'h7E57, 1'b1, 10);
        idle(4);

        // R7 seeded random mix
        for (int f = 0; f < 60; f++) begin
            logic [15:0] et;
            int          pick;
            pick = int'($urandom % 4);
            et = (pick < 2) ? 16'h88F7 : (pick == 2) ? 16'h86DD : 16'($urandom);
            send_frame(8 + int'($urandom % 65), et, 4'($urandom), 16'($urandom),
                       ($urandom % 5) != 0, int'($urandom % 30));
            idle(int'($urandom % 3));
        end
        idle(4);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule